// File: doc/BRIEF.md
# Packed Half-Precision Operand Swizzle and Result Merge

This block sits on both sides of a dual-lane FP16 arithmetic unit. On the way in, it turns 32-bit register words into pairs of FP16 lanes. Each source operand has a lane-select code. The code can pass both halves through, copy one half to both lanes, or read the word as a single FP32 number that is rounded to FP16 and copied to both lanes. After lane selection, an absolute-value modifier clears both lane signs, and then a negate modifier flips them. The second operand can instead come from a compact immediate. The immediate has two 9-bit fields, each placed inside its own lane, with a separate negate bit per lane.

On the way out, the block writes a two-lane FP16 result into a 32-bit destination under a merge code. The code can write both halves, widen lane 0 to a full FP32 word, or replace one half of the old destination and keep the other half. All transforms are combinational. A single output register stage with a valid/ready handshake presents the operand pair and the merged destination together.

Back-pressure rules:
- A transfer happens on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output stage is empty or is being drained in the same cycle (`out_ready` high).
- While `out_valid` is high and `out_ready` is low, the outputs hold their values and no new input is taken.

Top module: `fp16_pair_swizzle`

## Requirements
- R1: Lane-select code 0 returns word bits [15:0] as lane 0 (pair bits [15:0]) and word bits [31:16] as lane 1 (pair bits [31:16]).
- R2: Lane-select code 1 reads the word as FP32 and converts it to FP16 with round-to-nearest-even, then copies the result to both lanes. Values at or beyond the FP16 range become signed infinity (0x7C00 with the sign). Tiny values become FP16 subnormals or signed zero. Any NaN becomes 0x7E00.
- R3: Lane-select code 2 copies word bits [15:0] into both lanes. Code 3 copies word bits [31:16] into both lanes.
- R4: The absolute-value flag clears bits 15 and 31 of the pair. The negate flag is applied after it and inverts bits 15 and 31. Both flags act on lanes produced by any lane-select code.
- R5: When `b_from_imm` is high, operand B is the immediate. `imm_lo` sits in bits [14:6] and `imm_hi` sits in bits [30:22]. All other bits are zero.
- R6: When `imm_neg_en` is high, `imm_neg_lo` sets bit 15 and `imm_neg_hi` sets bit 31. When `imm_neg_en` is low, both negate bits have no effect.
- R7: Merge code 0 writes `res_pair` unchanged to the destination.
- R8: Merge code 1 writes lane 0 of `res_pair` widened exactly to FP32. FP16 subnormals are normalised, infinity keeps its sign, and any NaN becomes 0x7FC00000.
- R9: Merge code 2 writes lane 0 into bits [15:0] and keeps `old_dst` bits [31:16]. Merge code 3 writes lane 1 into bits [31:16] and keeps `old_dst` bits [15:0].
- R10: `in_ready` is high exactly when the output stage is empty or `out_ready` is high. An accepted input appears on the outputs one cycle later with `out_valid` high. While stalled, the outputs are held stable.
- R11: While `rst` is high and after it is released, `out_valid` is low until the first accepted input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input payload is valid |
| in_ready | output | 1 | Block can take the input payload |
| a_word | input | 32 | Source word for operand A |
| a_sel | input | 2 | Lane-select code for operand A |
| a_abs | input | 1 | Absolute-value flag for operand A |
| a_neg | input | 1 | Negate flag for operand A |
| b_word | input | 32 | Source word for operand B |
| b_sel | input | 2 | Lane-select code for operand B |
| b_abs | input | 1 | Absolute-value flag for operand B |
| b_neg | input | 1 | Negate flag for operand B |
| b_from_imm | input | 1 | Take operand B from the immediate fields |
| imm_lo | input | 9 | Immediate field for lane 0 |
| imm_hi | input | 9 | Immediate field for lane 1 |
| imm_neg_lo | input | 1 | Sign bit for immediate lane 0 |
| imm_neg_hi | input | 1 | Sign bit for immediate lane 1 |
| imm_neg_en | input | 1 | Enables the immediate sign bits |
| res_pair | input | 32 | Two-lane FP16 result from the arithmetic core |
| old_dst | input | 32 | Current contents of the destination register |
| merge_mode | input | 2 | Merge code for the destination write |
| out_valid | output | 1 | Output stage holds a result |
| out_ready | input | 1 | Downstream takes the output |
| out_a | output | 32 | Operand A lane pair |
| out_b | output | 32 | Operand B lane pair |
| out_dst | output | 32 | Merged destination word |

## Verification
The assertions assume the source holds a stable payload for the whole cycle in which it is accepted. They also assume that no input carries X, because relations such as "the upper half equals the old destination's upper half" compare against the value sampled at the accepting edge. The bench meets both assumptions: it changes inputs only at the falling edge and holds `in_valid` until it sees `in_ready` high. FP32 stimulus for lane-select code 1 is biased toward exponents near the FP16 range, so that rounding ties, subnormal results and overflow to infinity all occur, next to random words that often hold NaN and infinity.

// File: rtl/fp16_pair_swizzle_pkg.sv
`timescale 1ns/1ps
package fp16_pair_swizzle_pkg;

  localparam int WORD_W = 32;
  localparam int LANE_W = WORD_W / 2;

  localparam logic [LANE_W-1:0] HALF_QNAN = 16'h7E00;
  localparam logic [WORD_W-1:0] WIDE_QNAN = 32'h7FC00000;

  typedef enum logic [1:0] {
    SRC_PAIR = 2'd0,
    SRC_WIDE = 2'd1,
    SRC_LOW  = 2'd2,
    SRC_HIGH = 2'd3
  } src_sel_e;

  typedef enum logic [1:0] {
    MRG_PAIR   = 2'd0,
    MRG_WIDE   = 2'd1,
    MRG_LOW_IN = 2'd2,
    MRG_HI_IN  = 2'd3
  } merge_e;

  typedef struct packed {
    logic [WORD_W-1:0] opa;
    logic [WORD_W-1:0] opb;
    logic [WORD_W-1:0] dst;
  } stage_t;

endpackage

// File: rtl/fp16_narrow.sv
`timescale 1ns/1ps
module fp16_narrow
  import fp16_pair_swizzle_pkg::*;
(
  input  logic [WORD_W-1:0] wide_in,
  output logic [LANE_W-1:0] half_out
);
  logic        sgn;
  logic [7:0]  ex;
  logic [22:0] man;
  logic [23:0] sig;
  logic [47:0] ext;
  logic [4:0]  sh;
  logic [23:0] kept;
  logic        guard, sticky, up;
  logic [15:0] mag;

  always_comb begin
    sgn    = wide_in[31];
    ex     = wide_in[30:23];
    man    = wide_in[22:0];
    sig    = {(ex != 8'd0), man};
    ext    = '0;
    sh     = '0;
    kept   = '0;
    guard  = 1'b0;
    sticky = 1'b0;
    up     = 1'b0;
    mag    = '0;
    if (ex == 8'hFF) begin
      half_out = (man != 23'd0) ? HALF_QNAN : {sgn, 15'h7C00};
    end else if (ex >= 8'd143) begin
      half_out = {sgn, 15'h7C00};
    end else if (ex >= 8'd113) begin
      guard    = man[12];
      sticky   = |man[11:0];
      up       = guard & (sticky | man[13]);
      mag      = {1'b0, 5'(ex - 8'd112), man[22:13]} + {15'd0, up};
      half_out = {sgn, mag[14:0]};
    end else if (ex >= 8'd102) begin
      sh       = 5'(8'd126 - ex);
      ext      = {sig, 24'd0} >> sh;
      kept     = ext[47:24];
      guard    = ext[23];
      sticky   = |ext[22:0];
      up       = guard & (sticky | kept[0]);
      mag      = kept[15:0] + {15'd0, up};
      half_out = {sgn, mag[14:0]};
    end else begin
      half_out = {sgn, 15'd0};
    end
  end
endmodule

// File: rtl/fp16_widen.sv
`timescale 1ns/1ps
module fp16_widen
  import fp16_pair_swizzle_pkg::*;
(
  input  logic [LANE_W-1:0] half_in,
  output logic [WORD_W-1:0] wide_out
);
  logic        sgn;
  logic [4:0]  hex;
  logic [9:0]  hm;
  logic [3:0]  lead;
  logic [23:0] norm;

  always_comb begin
    sgn  = half_in[15];
    hex  = half_in[14:10];
    hm   = half_in[9:0];
    lead = '0;
    for (int i = 0; i < 10; i++) begin
      if (hm[i]) lead = 4'(i);
    end
    norm = {1'b0, hm, 13'd0} << (4'd10 - lead);
    if (hex == 5'h1F) begin
      wide_out = (hm != 10'd0) ? WIDE_QNAN : {sgn, 8'hFF, 23'd0};
    end else if (hex == 5'd0) begin
      if (hm == 10'd0) wide_out = {sgn, 31'd0};
      else             wide_out = {sgn, 8'd103 + {4'd0, lead}, norm[22:0]};
    end else begin
      wide_out = {sgn, {3'd0, hex} + 8'd112, hm, 13'd0};
    end
  end
endmodule

// File: rtl/fp16_src_unpack.sv
`timescale 1ns/1ps
module fp16_src_unpack
  import fp16_pair_swizzle_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        sel,
  input  logic              abs_en,
  input  logic              neg_en,
  output logic [WORD_W-1:0] pair
);
  logic [LANE_W-1:0] narrowed;
  logic [WORD_W-1:0] picked;
  src_sel_e          mode;

  fp16_narrow u_narrow (.wide_in(word), .half_out(narrowed));

  always_comb begin
    mode = src_sel_e'(sel);
    unique case (mode)
      SRC_PAIR: picked = word;
      SRC_WIDE: picked = {narrowed, narrowed};
      SRC_LOW:  picked = {word[LANE_W-1:0], word[LANE_W-1:0]};
      default:  picked = {word[WORD_W-1:LANE_W], word[WORD_W-1:LANE_W]};
    endcase
    pair = picked;
    if (abs_en) begin
      pair[LANE_W-1] = 1'b0;
      pair[WORD_W-1] = 1'b0;
    end
    if (neg_en) begin
      pair[LANE_W-1] = ~pair[LANE_W-1];
      pair[WORD_W-1] = ~pair[WORD_W-1];
    end
  end
endmodule

// File: rtl/fp16_imm_expand.sv
`timescale 1ns/1ps
module fp16_imm_expand
  import fp16_pair_swizzle_pkg::*;
#(
  parameter int IMM_W   = 9,
  parameter int IMM_POS = 6
) (
  input  logic [IMM_W-1:0]  field_lo,
  input  logic [IMM_W-1:0]  field_hi,
  input  logic              sgn_lo,
  input  logic              sgn_hi,
  input  logic              sgn_en,
  output logic [WORD_W-1:0] pair
);
  localparam int TOP_PAD = LANE_W - IMM_W - IMM_POS;

  logic [LANE_W-1:0] lane [2];
  logic [IMM_W-1:0]  fld  [2];
  logic              sgn  [2];

  assign fld[0] = field_lo;
  assign fld[1] = field_hi;
  assign sgn[0] = sgn_lo;
  assign sgn[1] = sgn_hi;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    always_comb begin
      lane[g] = {{TOP_PAD{1'b0}}, fld[g], {IMM_POS{1'b0}}};
      if (sgn_en) lane[g][LANE_W-1] = sgn[g];
    end
  end

  assign pair = {lane[1], lane[0]};
endmodule

// File: rtl/fp16_result_merge.sv
`timescale 1ns/1ps
module fp16_result_merge
  import fp16_pair_swizzle_pkg::*;
(
  input  logic [WORD_W-1:0] res,
  input  logic [WORD_W-1:0] old,
  input  logic [1:0]        mode,
  output logic [WORD_W-1:0] dst
);
  logic [WORD_W-1:0] widened;
  merge_e            m;

  fp16_widen u_widen (.half_in(res[LANE_W-1:0]), .wide_out(widened));

  always_comb begin
    m = merge_e'(mode);
    unique case (m)
      MRG_PAIR:   dst = res;
      MRG_WIDE:   dst = widened;
      MRG_LOW_IN: dst = {old[WORD_W-1:LANE_W], res[LANE_W-1:0]};
      default:    dst = {res[WORD_W-1:LANE_W], old[LANE_W-1:0]};
    endcase
  end
endmodule

// File: rtl/fp16_pair_swizzle.sv
`timescale 1ns/1ps
module fp16_pair_swizzle
  import fp16_pair_swizzle_pkg::*;
#(
  parameter int IMM_W   = 9,
  parameter int IMM_POS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       a_word,
  input  logic [1:0]        a_sel,
  input  logic              a_abs,
  input  logic              a_neg,
  input  logic [31:0]       b_word,
  input  logic [1:0]        b_sel,
  input  logic              b_abs,
  input  logic              b_neg,
  input  logic              b_from_imm,
  input  logic [IMM_W-1:0]  imm_lo,
  input  logic [IMM_W-1:0]  imm_hi,
  input  logic              imm_neg_lo,
  input  logic              imm_neg_hi,
  input  logic              imm_neg_en,
  input  logic [31:0]       res_pair,
  input  logic [31:0]       old_dst,
  input  logic [1:0]        merge_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_a,
  output logic [31:0]       out_b,
  output logic [31:0]       out_dst
);
  localparam int N_SRC = 2;

  logic [WORD_W-1:0] s_word [N_SRC];
  logic [1:0]        s_sel  [N_SRC];
  logic              s_abs  [N_SRC];
  logic              s_neg  [N_SRC];
  logic [WORD_W-1:0] s_pair [N_SRC];
  logic [WORD_W-1:0] imm_pair;
  logic [WORD_W-1:0] merged;
  stage_t            nxt, held;
  logic              take;

  assign s_word[0] = a_word;  assign s_sel[0] = a_sel;
  assign s_abs[0]  = a_abs;   assign s_neg[0] = a_neg;
  assign s_word[1] = b_word;  assign s_sel[1] = b_sel;
  assign s_abs[1]  = b_abs;   assign s_neg[1] = b_neg;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    fp16_src_unpack u_unpack (
      .word   (s_word[g]),
      .sel    (s_sel[g]),
      .abs_en (s_abs[g]),
      .neg_en (s_neg[g]),
      .pair   (s_pair[g])
    );
  end

  fp16_imm_expand #(.IMM_W(IMM_W), .IMM_POS(IMM_POS)) u_imm (
    .field_lo (imm_lo),
    .field_hi (imm_hi),
    .sgn_lo   (imm_neg_lo),
    .sgn_hi   (imm_neg_hi),
    .sgn_en   (imm_neg_en),
    .pair     (imm_pair)
  );

  fp16_result_merge u_merge (
    .res  (res_pair),
    .old  (old_dst),
    .mode (merge_mode),
    .dst  (merged)
  );

  always_comb begin
    nxt.opa = s_pair[0];
    nxt.opb = b_from_imm ? imm_pair : s_pair[1];
    nxt.dst = merged;
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      held      <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take)     held      <= nxt;
    end
  end

  assign out_a   = held.opa;
  assign out_b   = held.opb;
  assign out_dst = held.dst;
endmodule

// File: rtl/fp16_pair_swizzle_chk.sv
`timescale 1ns/1ps
module fp16_pair_swizzle_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic [1:0]  a_sel,
  input logic        a_abs,
  input logic        a_neg,
  input logic        b_from_imm,
  input logic [31:0] res_pair,
  input logic [31:0] old_dst,
  input logic [1:0]  merge_mode,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_a,
  input logic [31:0] out_b,
  input logic [31:0] out_dst
);
  logic fire;
  assign fire = in_valid && in_ready;

  p_accept_r10: assert property (@(posedge clk) disable iff (rst)
    fire |=> out_valid);

  p_stall_block_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_a) && $stable(out_b) && $stable(out_dst)));

  p_wide_bcast_r2: assert property (@(posedge clk) disable iff (rst)
    (fire && a_sel == 2'd1) |=> (out_a[31:16] == out_a[15:0]));

  p_half_bcast_r3: assert property (@(posedge clk) disable iff (rst)
    (fire && a_sel[1]) |=> (out_a[31:16] == out_a[15:0]));

  p_abs_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (fire && a_abs && !a_neg) |=> (!out_a[15] && !out_a[31]));

  p_imm_zero_bits_r5: assert property (@(posedge clk) disable iff (rst)
    (fire && b_from_imm) |=> (out_b[5:0] == 6'd0 && out_b[21:16] == 6'd0));

  p_pair_write_r7: assert property (@(posedge clk) disable iff (rst)
    (fire && merge_mode == 2'd0) |=> (out_dst == $past(res_pair)));

  p_keep_upper_r9: assert property (@(posedge clk) disable iff (rst)
    (fire && merge_mode == 2'd2) |=> (out_dst[31:16] == $past(old_dst[31:16])));

  p_keep_lower_r9: assert property (@(posedge clk) disable iff (rst)
    (fire && merge_mode == 2'd3) |=> (out_dst[15:0] == $past(old_dst[15:0])));
endmodule

bind fp16_pair_swizzle fp16_pair_swizzle_chk u_chk (.*);

// File: tb/fp16_pair_swizzle_test.sv
`timescale 1ns/1ps
module fp16_pair_swizzle_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst, in_valid, in_ready, out_valid, out_ready;
  logic [31:0] a_word, b_word, res_pair, old_dst, out_a, out_b, out_dst;
  logic [1:0]  a_sel, b_sel, merge_mode;
  logic        a_abs, a_neg, b_abs, b_neg, b_from_imm;
  logic [8:0]  imm_lo, imm_hi;
  logic        imm_neg_lo, imm_neg_hi, imm_neg_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  fp16_pair_swizzle uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_f2h(logic [31:0] f);
    logic s;
    int e, sh;
    logic [31:0] sig, n, rem, half, code;
    s   = f[31];
    e   = int'(f[30:23]);
    sig = {8'd0, (e != 0), f[22:0]};
    if (e == 255) return (f[22:0] != 23'd0) ? 16'h7E00 : {s, 15'h7C00};
    if (e >= 113) sh = 13;
    else if (e >= 102) sh = 126 - e;
    else return {s, 15'd0};
    n    = sig >> sh;
    rem  = sig & ((32'd1 << sh) - 32'd1);
    half = 32'd1 << (sh - 1);
    if (rem > half || (rem == half && n[0])) n = n + 32'd1;
    if (e >= 113) code = 32'((e - 113) << 10) + n;
    else          code = n;
    if (code >= 32'h7C00) code = 32'h7C00;
    return {s, code[14:0]};
  endfunction

  function automatic logic [31:0] ref_h2f(logic [15:0] h);
    logic s;
    int he, ex;
    logic [10:0] mm;
    s  = h[15];
    he = int'(h[14:10]);
    if (he == 31) return (h[9:0] != 10'd0) ? 32'h7FC00000 : {s, 8'hFF, 23'd0};
    if (he != 0) return {s, 8'(he + 112), h[9:0], 13'd0};
    if (h[9:0] == 10'd0) return {s, 31'd0};
    mm = {1'b0, h[9:0]};
    ex = 113;
    while (!mm[10]) begin
      mm = mm << 1;
      ex--;
    end
    return {s, 8'(ex), mm[9:0], 13'd0};
  endfunction

  function automatic logic [31:0] ref_src(logic [31:0] w, logic [1:0] sel, logic ab, logic ng);
    logic [31:0] p;
    logic [15:0] c;
    c = ref_f2h(w);
    case (sel)
      2'd0: p = w;
      2'd1: p = {c, c};
      2'd2: p = {w[15:0], w[15:0]};
      default: p = {w[31:16], w[31:16]};
    endcase
    if (ab) begin p[15] = 1'b0; p[31] = 1'b0; end
    if (ng) begin p[15] = ~p[15]; p[31] = ~p[31]; end
    return p;
  endfunction

  function automatic logic [31:0] ref_imm(logic [8:0] lo, logic [8:0] hi, logic nl, logic nh, logic en);
    logic [31:0] p;
    p = {1'b0, hi, 6'd0, 1'b0, lo, 6'd0};
    if (en) begin p[15] = nl; p[31] = nh; end
    return p;
  endfunction

  function automatic logic [31:0] ref_merge(logic [31:0] r, logic [31:0] o, logic [1:0] m);
    case (m)
      2'd0: return r;
      2'd1: return ref_h2f(r[15:0]);
      2'd2: return {o[31:16], r[15:0]};
      default: return {r[31:16], o[15:0]};
    endcase
  endfunction

  task automatic clear_payload();
    a_word = '0; a_sel = '0; a_abs = 0; a_neg = 0;
    b_word = '0; b_sel = '0; b_abs = 0; b_neg = 0; b_from_imm = 0;
    imm_lo = '0; imm_hi = '0; imm_neg_lo = 0; imm_neg_hi = 0; imm_neg_en = 0;
    res_pair = '0; old_dst = '0; merge_mode = '0;
  endtask

  // Caller sets the payload just after a falling edge.
  task automatic send(string tag);
    logic [31:0] ea, eb, ed;
    ea = ref_src(a_word, a_sel, a_abs, a_neg);
    eb = b_from_imm ? ref_imm(imm_lo, imm_hi, imm_neg_lo, imm_neg_hi, imm_neg_en)
                    : ref_src(b_word, b_sel, b_abs, b_neg);
    ed = ref_merge(res_pair, old_dst, merge_mode);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R10 out_valid"}, {31'd0, out_valid}, 32'd1);
    chk({tag, " out_a"}, out_a, ea);
    chk({tag, " out_b"}, out_b, eb);
    chk({tag, " out_dst"}, out_dst, ed);
  endtask

  task automatic wide_case(logic [31:0] w, string tag);
    @(negedge clk); clear_payload();
    a_word = w; a_sel = 2'd1;
    send(tag);
  endtask

  task automatic widen_case(logic [15:0] h, string tag);
    @(negedge clk); clear_payload();
    res_pair = {16'h1234, h}; merge_mode = 2'd1;
    send(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] ha, hb, hd;
    void'($urandom(32'd7781));
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    clear_payload();
    repeat (3) @(negedge clk);
    chk("R11 out_valid in reset", {31'd0, out_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 out_valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R10 in_ready idle", {31'd0, in_ready}, 32'd1);

    // R1 pass-through, R3 broadcasts, R4 modifiers
    @(negedge clk); clear_payload();
    a_word = 32'hC0003C00; b_word = 32'hBC004500; b_sel = 2'd0;
    send("R1 pass");
    @(negedge clk); clear_payload();
    a_word = 32'h8123C456; a_sel = 2'd2; b_word = 32'h8123C456; b_sel = 2'd3;
    send("R3 broadcast");
    @(negedge clk); clear_payload();
    a_word = 32'h8123C456; a_sel = 2'd0; a_abs = 1; a_neg = 1;
    b_word = 32'h0123C456; b_sel = 2'd3; b_neg = 1;
    send("R4 abs then neg");

    // R2 rounding corners
    wide_case(32'h3F800000, "R2 one");
    wide_case(32'h3F801000, "R2 tie even down");
    wide_case(32'h3F803000, "R2 tie odd up");
    wide_case(32'h477FE000, "R2 max finite");
    wide_case(32'h477FF000, "R2 round to inf");
    wide_case(32'hC7800000, "R2 overflow neg");
    wide_case(32'h33800000, "R2 min subnormal");
    wide_case(32'h33000000, "R2 half min tie zero");
    wide_case(32'h33000001, "R2 above half min");
    wide_case(32'h387FE000, "R2 subnormal to normal");
    wide_case(32'h7FC00001, "R2 nan");
    wide_case(32'hFF800000, "R2 neg inf");

    // R5 R6 immediates
    @(negedge clk); clear_payload();
    b_from_imm = 1; imm_lo = 9'h1FF; imm_hi = 9'h0A5;
    imm_neg_lo = 1; imm_neg_hi = 0; imm_neg_en = 0;
    send("R6 neg disabled");
    @(negedge clk); clear_payload();
    b_from_imm = 1; imm_lo = 9'h0F0; imm_hi = 9'h1C3;
    imm_neg_lo = 0; imm_neg_hi = 1; imm_neg_en = 1;
    send("R5 R6 neg hi only");

    // R7 R8 R9 merges
    @(negedge clk); clear_payload();
    res_pair = 32'hABCD1234; old_dst = 32'h55667788; merge_mode = 2'd0;
    send("R7 pair");
    widen_case(16'h3C00, "R8 one");
    widen_case(16'h0001, "R8 min subnormal");
    widen_case(16'h83FF, "R8 neg max subnormal");
    widen_case(16'h7C01, "R8 nan");
    widen_case(16'hFC00, "R8 neg inf");
    @(negedge clk); clear_payload();
    res_pair = 32'hABCD1234; old_dst = 32'h55667788; merge_mode = 2'd2;
    send("R9 low in");
    @(negedge clk); clear_payload();
    res_pair = 32'hABCD1234; old_dst = 32'h55667788; merge_mode = 2'd3;
    send("R9 high in");

    // R10 back-pressure
    @(negedge clk); clear_payload();
    out_ready = 1'b0;
    a_word = 32'h11112222; res_pair = 32'h33334444;
    send("R10 stall first");
    ha = out_a; hb = out_b; hd = out_dst;
    clear_payload();
    a_word = 32'h99998888; res_pair = 32'h77776666; in_valid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R10 in_ready low while stalled", {31'd0, in_ready}, 32'd0);
      chk("R10 out_a held", out_a, ha);
      chk("R10 out_b held", out_b, hb);
      chk("R10 out_dst held", out_dst, hd);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 drained out_a", out_a, 32'h99998888);
    chk("R10 drained out_dst", out_dst, 32'h77776666);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); clear_payload();
      a_sel = 2'($urandom_range(0, 3));
      b_sel = 2'($urandom_range(0, 3));
      a_word = $urandom;
      b_word = $urandom;
      if (a_sel == 2'd1 && $urandom_range(0, 1) == 1)
        a_word = {1'($urandom), 8'(95 + $urandom_range(0, 55)), 23'($urandom)};
      if (b_sel == 2'd1 && $urandom_range(0, 1) == 1)
        b_word = {1'($urandom), 8'(95 + $urandom_range(0, 55)), 23'($urandom)};
      a_abs = 1'($urandom); a_neg = 1'($urandom);
      b_abs = 1'($urandom); b_neg = 1'($urandom);
      b_from_imm = 1'($urandom);
      imm_lo = 9'($urandom); imm_hi = 9'($urandom);
      imm_neg_lo = 1'($urandom); imm_neg_hi = 1'($urandom); imm_neg_en = 1'($urandom);
      res_pair = $urandom; old_dst = $urandom;
      merge_mode = 2'($urandom_range(0, 3));
      send("R1/R2/R3/R4/R5/R6/R7/R8/R9 random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule